// File: doc/BRIEF.md
# Crossbar Bid Lane Controller

This block sits in a first-stage module of a three-stage switch fabric. It keeps one bid lane for each center-stage crossbar. Every clock cycle is one time slot. In each slot a lane either holds one candidate cell, which it offers as a bid (destination group and priority), or holds nothing and offers no bid. The crossbar answers each bid with a two-bit feedback code. From that code the lane decides what to do in the next slot:

- After a win, it tells the datapath to forward the cell and at once takes a fresh candidate.
- After a contention loss, it repeats the identical bid.
- After a buffer-full refusal from the output stage, it hands the cell back to the selector and takes a different one.

Candidate cells come from an external selector that serves one request port per lane. The selector holds the queue storage and the weighted choice among the output-port groups. The selector, not this block, keeps cells queued. The block only names, by a release strobe, a cell that the selector may offer again later. Each input module runs its own copy of this block and exchanges no signal with the others.

Top module: `inmod_bid_ctrl`

## Requirements
- R1: While `rst` is high, `sel_req` and `rel_valid` are all low. After a reset edge, `bid_valid` and `xmit_valid` are all low.
- R2: Feedback code 0 (win) on a lane holding a bid makes `xmit_valid` high with that cell's id on the same lane in the next cycle. In the cycle of the code, the lane raises `sel_req` and loads the offered candidate.
- R3: Feedback code 1 (contention lost) or code 3 leaves the lane's bid (valid, group, priority, id) unchanged in the next cycle. In the cycle of the code it raises no `sel_req` and no `rel_valid`, and no transmit follows.
- R4: Feedback code 2 (backpressure) on a lane holding a bid raises `rel_valid` with the held cell id in the same cycle and raises `sel_req`. The next bid on that lane is the newly offered cell, never the released one.
- R5: A lane holding no bid raises `sel_req`. When `sel_avail` is high for that lane, the offered cell becomes its bid in the next cycle.
- R6: A lane that raises `sel_req` while its `sel_avail` is low holds no bid in the next cycle, with `bid_valid` low.
- R7: The feedback code presented to a lane that holds no bid has no effect on that lane.
- R8: Each lane acts only on its own feedback code and its own selector response, whatever the other lanes receive.
- R9: A loaded bid carries the candidate's group and priority fields unchanged on `bid_group` and `bid_prio`.
- R10: Given distinct candidates from the selector, no two lanes hold the same cell id at once, and no cell id is transmitted twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one time slot |
| rst | input | 1 | Synchronous active-high reset |
| fb_code | input | NUM_LANES*2 | Per-lane crossbar feedback for the bid held in this slot |
| sel_avail | input | NUM_LANES | Per-lane: selector has a candidate on offer |
| sel_group | input | NUM_LANES*GRP_W | Per-lane candidate output-port group |
| sel_prio | input | NUM_LANES*PRIO_W | Per-lane candidate priority |
| sel_id | input | NUM_LANES*CELL_W | Per-lane candidate cell id |
| sel_req | output | NUM_LANES | Per-lane: lane takes the offered candidate this cycle |
| bid_valid | output | NUM_LANES | Per-lane: a bid is held and sent |
| bid_group | output | NUM_LANES*GRP_W | Destination group of each bid |
| bid_prio | output | NUM_LANES*PRIO_W | Priority of each bid |
| bid_id | output | NUM_LANES*CELL_W | Cell id of each bid |
| xmit_valid | output | NUM_LANES | Per-lane: forward the won cell in this slot |
| xmit_id | output | NUM_LANES*CELL_W | Cell id to forward |
| rel_valid | output | NUM_LANES | Per-lane: return the held cell to the selector |
| rel_id | output | NUM_LANES*CELL_W | Cell id being returned |

## Verification
The bench focuses on the three-way split of feedback codes. A design that treated backpressure like a contention loss would resend the refused bid and never raise the release strobe. A design that treated a loss like backpressure would lose the held bid and request a new cell. The bench puts codes on idle lanes and reserved code 3 on busy lanes: a decoder that acts on stale feedback would transmit a cell that never won. It also withholds candidates on requesting lanes, which catches a lane that keeps a stale bid valid. Every cell id the bench offers is distinct, so a duplicate transmit or a cell pending on two lanes points to a wrong load or hold path.

// File: rtl/bidc_pkg.sv
package bidc_pkg;

    // Crossbar feedback encoding for the bid held in a slot
    typedef enum logic [1:0] {
        FB_WIN    = 2'd0,
        FB_LOST   = 2'd1,
        FB_BACKP  = 2'd2,
        FB_RSVD   = 2'd3
    } fb_code_e;

    // Action a lane takes at the end of a slot
    typedef enum logic [1:0] {
        ACT_IDLE     = 2'd0,   // nothing held: fetch a candidate
        ACT_SEND     = 2'd1,   // won: forward cell, fetch next
        ACT_RETRY    = 2'd2,   // lost contention: resend same bid
        ACT_RESELECT = 2'd3    // refused by backpressure: hand back, fetch other
    } lane_act_e;

    function automatic lane_act_e classify(input logic held, input logic [1:0] code);
        lane_act_e a;
        if (!held) begin
            a = ACT_IDLE;
        end else begin
            case (fb_code_e'(code))
                FB_WIN:   a = ACT_SEND;
                FB_BACKP: a = ACT_RESELECT;
                default:  a = ACT_RETRY;
            endcase
        end
        return a;
    endfunction

    function automatic logic wants_new(input lane_act_e a);
        return (a != ACT_RETRY);
    endfunction

endpackage

// File: rtl/bidc_fb_decode.sv
module bidc_fb_decode
    import bidc_pkg::*;
(
    input  logic       held,
    input  logic [1:0] code,
    output lane_act_e  act,
    output logic       need_new
);
    always_comb begin
        act      = classify(held, code);
        need_new = wants_new(act);
    end
endmodule

// File: rtl/bidc_lane.sv
module bidc_lane
    import bidc_pkg::*;
#(
    parameter int GRP_W  = 6,
    parameter int PRIO_W = 2,
    parameter int CELL_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        fb_code,
    input  logic              sel_avail,
    input  logic [GRP_W-1:0]  sel_group,
    input  logic [PRIO_W-1:0] sel_prio,
    input  logic [CELL_W-1:0] sel_id,
    output logic              sel_req,
    output logic              bid_valid,
    output logic [GRP_W-1:0]  bid_group,
    output logic [PRIO_W-1:0] bid_prio,
    output logic [CELL_W-1:0] bid_id,
    output logic              xmit_valid,
    output logic [CELL_W-1:0] xmit_id,
    output logic              rel_valid,
    output logic [CELL_W-1:0] rel_id
);
    typedef struct packed {
        logic [GRP_W-1:0]  grp;
        logic [PRIO_W-1:0] prio;
        logic [CELL_W-1:0] id;
    } cand_t;

    lane_act_e act;
    logic      need_new;
    logic      held_q;
    cand_t     held_c;
    cand_t     offer_c;

    bidc_fb_decode u_dec (
        .held     (held_q),
        .code     (fb_code),
        .act      (act),
        .need_new (need_new)
    );

    assign offer_c   = '{grp: sel_group, prio: sel_prio, id: sel_id};
    assign sel_req   = need_new & ~rst;
    assign rel_valid = (act == ACT_RESELECT) & ~rst;
    assign rel_id    = held_c.id;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q     <= 1'b0;
            held_c     <= '0;
            xmit_valid <= 1'b0;
            xmit_id    <= '0;
        end else begin
            xmit_valid <= (act == ACT_SEND);
            if (act == ACT_SEND)
                xmit_id <= held_c.id;
            if (need_new) begin
                held_q <= sel_avail;
                if (sel_avail)
                    held_c <= offer_c;
            end
        end
    end

    assign bid_valid = held_q;
    assign bid_group = held_c.grp;
    assign bid_prio  = held_c.prio;
    assign bid_id    = held_c.id;

    // R2: a won bid is forwarded in the following slot
    assert_win_xmit_R2: assert property (@(posedge clk) disable iff (rst)
        (bid_valid && fb_code == 2'd0) |=> (xmit_valid && xmit_id == $past(bid_id)));

    // R3: a lost bid is repeated unchanged
    assert_lost_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (bid_valid && fb_code[0]) |=> (bid_valid && $stable(bid_id) && $stable(bid_group)
                                        && $stable(bid_prio) && !xmit_valid));

    // R4: a refused cell is not bid again on this lane next slot
    assert_backp_other_R4: assert property (@(posedge clk) disable iff (rst)
        (bid_valid && fb_code == 2'd2) |=> (!bid_valid || bid_id != $past(bid_id)));

    // R6: a request with nothing on offer leaves the lane empty
    assert_empty_lane_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_req && !sel_avail) |=> !bid_valid);

    // R7: no bid held means no transmit follows
    assert_idle_noxmit_R7: assert property (@(posedge clk) disable iff (rst)
        !bid_valid |=> !xmit_valid);
endmodule

// File: rtl/inmod_bid_ctrl.sv
module inmod_bid_ctrl
    import bidc_pkg::*;
#(
    parameter int NUM_LANES  = 8,
    parameter int NUM_GROUPS = 40,
    parameter int PRIO_W     = 2,
    parameter int CELL_W     = 10,
    localparam int GRP_W     = $clog2(NUM_GROUPS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_LANES*2-1:0]      fb_code,
    input  logic [NUM_LANES-1:0]        sel_avail,
    input  logic [NUM_LANES*GRP_W-1:0]  sel_group,
    input  logic [NUM_LANES*PRIO_W-1:0] sel_prio,
    input  logic [NUM_LANES*CELL_W-1:0] sel_id,
    output logic [NUM_LANES-1:0]        sel_req,
    output logic [NUM_LANES-1:0]        bid_valid,
    output logic [NUM_LANES*GRP_W-1:0]  bid_group,
    output logic [NUM_LANES*PRIO_W-1:0] bid_prio,
    output logic [NUM_LANES*CELL_W-1:0] bid_id,
    output logic [NUM_LANES-1:0]        xmit_valid,
    output logic [NUM_LANES*CELL_W-1:0] xmit_id,
    output logic [NUM_LANES-1:0]        rel_valid,
    output logic [NUM_LANES*CELL_W-1:0] rel_id
);
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        bidc_lane #(
            .GRP_W  (GRP_W),
            .PRIO_W (PRIO_W),
            .CELL_W (CELL_W)
        ) u_lane (
            .clk        (clk),
            .rst        (rst),
            .fb_code    (fb_code[l*2 +: 2]),
            .sel_avail  (sel_avail[l]),
            .sel_group  (sel_group[l*GRP_W +: GRP_W]),
            .sel_prio   (sel_prio[l*PRIO_W +: PRIO_W]),
            .sel_id     (sel_id[l*CELL_W +: CELL_W]),
            .sel_req    (sel_req[l]),
            .bid_valid  (bid_valid[l]),
            .bid_group  (bid_group[l*GRP_W +: GRP_W]),
            .bid_prio   (bid_prio[l*PRIO_W +: PRIO_W]),
            .bid_id     (bid_id[l*CELL_W +: CELL_W]),
            .xmit_valid (xmit_valid[l]),
            .xmit_id    (xmit_id[l*CELL_W +: CELL_W]),
            .rel_valid  (rel_valid[l]),
            .rel_id     (rel_id[l*CELL_W +: CELL_W])
        );
    end

    // R10: pending cells are held by at most one lane
    for (genvar a = 0; a < NUM_LANES; a++) begin : g_pa
        for (genvar b = a + 1; b < NUM_LANES; b++) begin : g_pb
            assert_unique_pending_R10: assert property (@(posedge clk) disable iff (rst)
                (bid_valid[a] && bid_valid[b]) |->
                    (bid_id[a*CELL_W +: CELL_W] != bid_id[b*CELL_W +: CELL_W]));
        end
    end

    // R1: reset clears every lane
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (bid_valid == '0 && xmit_valid == '0));
endmodule

// File: tb/test_inmod_bid_ctrl.sv
module test_inmod_bid_ctrl;
    localparam int NL    = 8;
    localparam int NG    = 40;
    localparam int PW    = 2;
    localparam int CW    = 12;
    localparam int GW    = $clog2(NG);
    localparam int NVEC  = 12;
    localparam int NRAND = 180;

    // {avail mask, per-lane codes lane7..lane0}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'hFF, 16'h0000}, {8'hFF, 16'h5555}, {8'hFF, 16'hAAAA}, {8'hFF, 16'hFFFF},
        {8'h0F, 16'h0000}, {8'hFF, 16'h1B1B}, {8'hF0, 16'hAAAA}, {8'hFF, 16'h0000},
        {8'h00, 16'h0000}, {8'hFF, 16'h6C39}, {8'h5A, 16'h9999}, {8'hFF, 16'h0000}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NL*2-1:0]   fb_code = '0;
    logic [NL-1:0]     sel_avail = '0;
    logic [NL*GW-1:0]  sel_group = '0;
    logic [NL*PW-1:0]  sel_prio = '0;
    logic [NL*CW-1:0]  sel_id = '0;
    logic [NL-1:0]     sel_req, bid_valid, xmit_valid, rel_valid;
    logic [NL*GW-1:0]  bid_group;
    logic [NL*PW-1:0]  bid_prio;
    logic [NL*CW-1:0]  bid_id, xmit_id, rel_id;

    always #2 clk = ~clk;

    inmod_bid_ctrl #(.NUM_LANES(NL), .NUM_GROUPS(NG), .PRIO_W(PW), .CELL_W(CW)) i_inmod_bid_ctrl (
        .clk(clk), .rst(rst), .fb_code(fb_code), .sel_avail(sel_avail),
        .sel_group(sel_group), .sel_prio(sel_prio), .sel_id(sel_id),
        .sel_req(sel_req), .bid_valid(bid_valid), .bid_group(bid_group),
        .bid_prio(bid_prio), .bid_id(bid_id), .xmit_valid(xmit_valid),
        .xmit_id(xmit_id), .rel_valid(rel_valid), .rel_id(rel_id)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;
    int base = 1;

    logic          m_v   [NL];
    logic [CW-1:0] m_id  [NL];
    logic [GW-1:0] m_g   [NL];
    logic [PW-1:0] m_p   [NL];
    logic          e_x   [NL];
    logic [CW-1:0] e_xid [NL];
    bit            seen  [1<<CW];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [GW-1:0] grp_of(input int id);
        return GW'(id % NG);
    endfunction

    function automatic logic [PW-1:0] prio_of(input int id);
        return PW'(id >> 2);
    endfunction

    task automatic model_reset();
        for (int l = 0; l < NL; l++) begin
            m_v[l] = 1'b0; m_id[l] = '0; m_g[l] = '0; m_p[l] = '0;
            e_x[l] = 1'b0; e_xid[l] = '0;
        end
    endtask

    // Called at a negedge. Drives one slot, checks combinational outputs,
    // advances the model, then checks the registered outputs at the next negedge.
    task automatic slot(input logic [NL-1:0] av, input logic [NL*2-1:0] codes);
        fb_code   = codes;
        sel_avail = av;
        for (int l = 0; l < NL; l++) begin
            sel_id[l*CW +: CW]    = CW'(base + l);
            sel_group[l*GW +: GW] = grp_of(base + l);
            sel_prio[l*PW +: PW]  = prio_of(base + l);
        end
        #1;
        for (int l = 0; l < NL; l++) begin
            logic [1:0] c;
            bit win, bp, need;
            c    = codes[l*2 +: 2];
            win  = m_v[l] && c == 2'd0;
            bp   = m_v[l] && c == 2'd2;
            need = !m_v[l] || win || bp;
            // R2 R4 R5 R3 R7: request only when a new candidate is wanted
            chk(sel_req[l] == need, "R3/R5 sel_req", sel_req[l], need);
            chk(rel_valid[l] == bp, "R4 rel_valid", rel_valid[l], bp);
            if (bp) chk(rel_id[l*CW +: CW] == m_id[l], "R4 rel_id", rel_id[l*CW +: CW], m_id[l]);
            e_x[l]   = win;
            e_xid[l] = m_id[l];
            if (need) begin
                m_v[l] = av[l];
                if (av[l]) begin
                    m_id[l] = CW'(base + l);
                    m_g[l]  = grp_of(base + l);
                    m_p[l]  = prio_of(base + l);
                end
            end
        end
        base += NL;
        @(posedge clk);
        @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            chk(bid_valid[l] == m_v[l], "R6 bid_valid", bid_valid[l], m_v[l]);
            if (m_v[l]) begin
                chk(bid_id[l*CW +: CW] == m_id[l], "R3/R5 bid_id", bid_id[l*CW +: CW], m_id[l]);
                chk(bid_group[l*GW +: GW] == m_g[l], "R9 bid_group", bid_group[l*GW +: GW], m_g[l]);
                chk(bid_prio[l*PW +: PW] == m_p[l], "R9 bid_prio", bid_prio[l*PW +: PW], m_p[l]);
            end
            chk(xmit_valid[l] == e_x[l], "R2/R7 xmit_valid", xmit_valid[l], e_x[l]);
            if (e_x[l]) begin
                chk(xmit_id[l*CW +: CW] == e_xid[l], "R2 xmit_id", xmit_id[l*CW +: CW], e_xid[l]);
            end
            if (xmit_valid[l]) begin
                // R10: each cell forwarded once
                chk(!seen[xmit_id[l*CW +: CW]], "R10 duplicate xmit", xmit_id[l*CW +: CW], 0);
                seen[xmit_id[l*CW +: CW]] = 1'b1;
            end
            for (int k = l + 1; k < NL; k++) begin
                if (bid_valid[l] && bid_valid[k])
                    chk(bid_id[l*CW +: CW] != bid_id[k*CW +: CW], "R10 shared pending",
                        bid_id[k*CW +: CW], 0);
            end
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(bid_valid == '0, "R1 bid_valid", bid_valid, 0);
        chk(xmit_valid == '0, "R1 xmit_valid", xmit_valid, 0);
        chk(sel_req == '0, "R1 sel_req", sel_req, 0);
        chk(rel_valid == '0, "R1 rel_valid", rel_valid, 0);
        rst = 1'b0;

        // Vector table walk (R2..R9 across mixed code patterns)
        for (int v = 0; v < NVEC; v++) begin
            slot(VEC[v][23:16], VEC[v][15:0]);
        end

        // Random feedback per lane (R8 independence, R10 uniqueness)
        for (int i = 0; i < NRAND; i++) begin
            slot(NL'($urandom | $urandom), (NL*2)'($urandom));
        end

        // R3: reserved code 3 on every busy lane keeps bids
        slot('1, '0);
        slot('0, '1);
        // R6: all lanes requesting with nothing offered
        slot('0, {NL{2'd2}});
        // R7: codes on idle lanes are ignored
        slot('0, {NL{2'd0}});
        slot('1, {NL{2'd1}});

        // R1: mid-run reset clears held bids
        fb_code = {NL{2'd1}};
        rst = 1'b1;
        #1;
        chk(sel_req == '0, "R1 sel_req in reset", sel_req, 0);
        chk(rel_valid == '0, "R1 rel_valid in reset", rel_valid, 0);
        @(posedge clk);
        @(negedge clk);
        chk(bid_valid == '0, "R1 bid_valid after reset", bid_valid, 0);
        chk(xmit_valid == '0, "R1 xmit_valid after reset", xmit_valid, 0);
        model_reset();
        rst = 1'b0;
        slot('1, '0);
        slot('1, '0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule